// File: doc/BRIEF.md
# Paged Memory Expansion Address Translator

This block sits between a 16-bit CPU address bus and external memory and lets the CPU reach up to 256 KB through a paged window. The upper six CPU address bits form a 1 KB block number. When that block number falls inside a programmable window, the block adds an 8-bit page offset to it. The low six bits of the sum replace the external upper address bits. Depending on the operating mode, zero, one or two bits of the sum above them drive two extended address lines.

Accesses inside the window also pull a program chip-select low. Outside the window, and in the mode without expansion, the CPU address passes through unchanged. An extended line that the current mode does not claim falls back to a general-purpose output. That output's value comes from a small data register.

Software programs the mode, offset, window bounds and fallback data through a simple synchronous write port. The translation itself is combinational from the CPU address and the stored registers.

Top module: `mem_page_xlat`

## Requirements
- R1: The mode field is `wr_data[1:0]` written to selector 0. Its codes are 0 for no expansion, 1 for 64 KB expansion, 2 for 128 KB expansion and 3 for 256 KB expansion.
- R2: `addr_out[9:0]` always equals `cpu_addr[9:0]`, in every mode and whether or not the access is in the window.
- R3: In modes 1 to 3, an in-window access drives `addr_out[15:10]` with bits [5:0] of the 8-bit sum `offset + {2'b00, cpu_addr[15:10]}`.
- R4: When the access is outside the window, or the mode is 0, `addr_out[15:10]` equals `cpu_addr[15:10]`.
- R5: `cs_prog_n` is low exactly when the mode is not 0 and the window start ≤ `cpu_addr[15:10]` ≤ the window end, with both bounds inclusive. A start above the end gives an empty window.
- R6: In modes 0 and 1, both `xa_out` pins carry the fallback data register and `xa_addr_en` is 2'b00.
- R7: In mode 2, `xa_out[0]` carries sum bit 6 for an in-window access and offset bit 6 otherwise, with `xa_addr_en` = 2'b01. `xa_out[1]` carries fallback data bit 1.
- R8: In mode 3, `xa_out[1:0]` carry sum bits [7:6] for an in-window access and offset bits [7:6] otherwise, with `xa_addr_en` = 2'b11. The carry out of sum bit 7 is discarded.
- R9: After reset, the mode is 0, the offset and both window bounds are 0, and the fallback data is 2'b11. As a result, `xa_out` = 2'b11 and `cs_prog_n` = 1.
- R10: Register writes take effect from the clock edge on which `wr_en` is high, with these selectors:
  - selector 0: mode;
  - selector 1: offset, `wr_data[7:0]`;
  - selector 2: window start, `wr_data[5:0]`;
  - selector 3: window end, `wr_data[5:0]`;
  - selector 4: fallback data, `wr_data[1:0]`.
  
  Selectors 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address |
| addr_out | output | 16 | Translated external address |
| xa_out | output | 2 | Extended address lines or fallback data |
| xa_addr_en | output | 2 | Per pin: 1 when the pin carries address, 0 for fallback |
| cs_prog_n | output | 1 | Program chip-select, active low |

## Verification
On every cycle, the assertions check four relations:
- the chip-select stays high with expansion off;
- a low chip-select only occurs for a block inside the stored bounds;
- a high chip-select always leaves the upper address untranslated;
- both extended lines fall back to the data register in modes 0 and 1.

A further assertion checks that an offset write lands in the following cycle. The arithmetic itself can only be shown by the bench's scenarios:
- the sum values;
- the dropped carry at block 63 with a large offset;
- the inclusive edges of the window and an empty window;
- the routing of sum bits versus offset bits onto the extended lines in modes 2 and 3.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
   // Expansion modes, ordered so that mode value >= (2 + pin) claims extended pin
   typedef enum logic [1:0] {
      XM_NONE = 2'd0,
      XM_64K  = 2'd1,
      XM_128K = 2'd2,
      XM_256K = 2'd3
   } xmode_e;

   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      RS_MODE = 3'd0,
      RS_OFS  = 3'd1,
      RS_WLO  = 3'd2,
      RS_WHI  = 3'd3,
      RS_GPIO = 3'd4
   } rsel_e;
endpackage

// File: rtl/pxl_regfile.sv
module pxl_regfile
   import pxl_pkg::*;
#(
   parameter int unsigned BLK_W = 6,
   parameter int unsigned XA_W  = 2,
   localparam int unsigned OFS_W = BLK_W + XA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [OFS_W-1:0] wr_data,
   output xmode_e           mode_q,
   output logic [OFS_W-1:0] ofs_q,
   output logic [BLK_W-1:0] wlo_q,
   output logic [BLK_W-1:0] whi_q,
   output logic [XA_W-1:0]  gpio_q
);

   if (OFS_W < 2) begin : g_bad_width
      $error("pxl_regfile: data too narrow for mode field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= XM_NONE;
         ofs_q  <= '0;
         wlo_q  <= '0;
         whi_q  <= '0;
         gpio_q <= '1;
      end else if (wr_en) begin
         case (rsel_e'(wr_sel))
            RS_MODE: mode_q <= xmode_e'(wr_data[1:0]);
            RS_OFS:  ofs_q  <= wr_data;
            RS_WLO:  wlo_q  <= wr_data[BLK_W-1:0];
            RS_WHI:  whi_q  <= wr_data[BLK_W-1:0];
            RS_GPIO: gpio_q <= wr_data[XA_W-1:0];
            default: ;
         endcase
      end
   end

   // R10
   ofs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == RS_OFS) |=> (ofs_q == $past(wr_data)));

   // R10
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel > RS_GPIO) |=> ($stable(ofs_q) && $stable(wlo_q) && $stable(whi_q)));

endmodule

// File: rtl/pxl_window.sv
module pxl_window
   import pxl_pkg::*;
#(
   parameter int unsigned BLK_W = 6
) (
   input  xmode_e           mode,
   input  logic [BLK_W-1:0] blk,
   input  logic [BLK_W-1:0] lo,
   input  logic [BLK_W-1:0] hi,
   output logic             hit
);

   logic above_lo;
   logic below_hi;

   // Inclusive compare on both bounds; lo > hi leaves the window empty
   always_comb begin
      above_lo = (blk >= lo);
      below_hi = (blk <= hi);
      hit      = (mode != XM_NONE) && above_lo && below_hi;
   end

endmodule

// File: rtl/pxl_route.sv
module pxl_route
   import pxl_pkg::*;
#(
   parameter int unsigned BLK_W = 6,
   parameter int unsigned XA_W  = 2,
   localparam int unsigned OFS_W = BLK_W + XA_W
) (
   input  xmode_e           mode,
   input  logic             hit,
   input  logic [BLK_W-1:0] blk,
   input  logic [OFS_W-1:0] ofs,
   input  logic [XA_W-1:0]  gpio,
   output logic [BLK_W-1:0] up_blk,
   output logic [XA_W-1:0]  xa,
   output logic [XA_W-1:0]  xa_en
);

   if (XA_W < 1 || XA_W > 2) begin : g_bad_xa
      $error("pxl_route: mode field covers one or two extended lines");
   end

   // Sum kept at offset width: the carry above the top extended line is dropped
   logic [OFS_W-1:0] sum;

   always_comb begin
      sum    = ofs + OFS_W'(blk);
      up_blk = hit ? sum[BLK_W-1:0] : blk;
   end

   for (genvar i = 0; i < XA_W; i++) begin : g_xa
      localparam int MIN_MODE = i + 2;
      always_comb begin
         xa_en[i] = (int'(mode) >= MIN_MODE);
         if (xa_en[i]) xa[i] = hit ? sum[BLK_W+i] : ofs[BLK_W+i];
         else          xa[i] = gpio[i];
      end
   end

endmodule

// File: rtl/mem_page_xlat.sv
module mem_page_xlat
   import pxl_pkg::*;
#(
   parameter int unsigned CPU_W  = 16,
   parameter int unsigned PAGE_W = 10,
   parameter int unsigned XA_W   = 2,
   localparam int unsigned BLK_W = CPU_W - PAGE_W,
   localparam int unsigned OFS_W = BLK_W + XA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [OFS_W-1:0] wr_data,
   input  logic [CPU_W-1:0] cpu_addr,
   output logic [CPU_W-1:0] addr_out,
   output logic [XA_W-1:0]  xa_out,
   output logic [XA_W-1:0]  xa_addr_en,
   output logic             cs_prog_n
);

   if (PAGE_W == 0 || PAGE_W >= CPU_W) begin : g_bad_page
      $error("mem_page_xlat: page size must leave block bits");
   end

   xmode_e           mode_q;
   logic [OFS_W-1:0] ofs_q;
   logic [BLK_W-1:0] wlo_q;
   logic [BLK_W-1:0] whi_q;
   logic [XA_W-1:0]  gpio_q;
   logic [BLK_W-1:0] blk;
   logic [BLK_W-1:0] up_blk;
   logic             hit;

   assign blk = cpu_addr[CPU_W-1:PAGE_W];

   pxl_regfile #(.BLK_W(BLK_W), .XA_W(XA_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .mode_q (mode_q),
      .ofs_q  (ofs_q),
      .wlo_q  (wlo_q),
      .whi_q  (whi_q),
      .gpio_q (gpio_q)
   );

   pxl_window #(.BLK_W(BLK_W)) u_win (
      .mode(mode_q),
      .blk (blk),
      .lo  (wlo_q),
      .hi  (whi_q),
      .hit (hit)
   );

   pxl_route #(.BLK_W(BLK_W), .XA_W(XA_W)) u_route (
      .mode  (mode_q),
      .hit   (hit),
      .blk   (blk),
      .ofs   (ofs_q),
      .gpio  (gpio_q),
      .up_blk(up_blk),
      .xa    (xa_out),
      .xa_en (xa_addr_en)
   );

   assign addr_out  = {up_blk, cpu_addr[PAGE_W-1:0]};
   assign cs_prog_n = ~hit;

   // R5
   cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == XM_NONE) |-> cs_prog_n);

   // R5
   cs_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_prog_n |-> (blk >= wlo_q && blk <= whi_q));

   // R4
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_prog_n |-> (addr_out[CPU_W-1:PAGE_W] == cpu_addr[CPU_W-1:PAGE_W]));

   // R6
   xa_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q inside {XM_NONE, XM_64K}) |-> (xa_out == gpio_q && xa_addr_en == '0));

endmodule

// File: tb/mem_page_xlat_test.sv
module mem_page_xlat_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] addr_out;
   logic [1:0]  xa_out;
   logic [1:0]  xa_addr_en;
   logic        cs_prog_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Shadow of the programmed state, kept from the requirements
   logic [1:0] m_mode = 2'd0;
   logic [7:0] m_ofs  = 8'd0;
   logic [5:0] m_lo   = 6'd0;
   logic [5:0] m_hi   = 6'd0;
   logic [1:0] m_gpio = 2'b11;

   always #5 clk = ~clk;

   mem_page_xlat uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .cpu_addr  (cpu_addr),
      .addr_out  (addr_out),
      .xa_out    (xa_out),
      .xa_addr_en(xa_addr_en),
      .cs_prog_n (cs_prog_n)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] sel, logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      case (sel)
         3'd0: m_mode = data[1:0];
         3'd1: m_ofs  = data;
         3'd2: m_lo   = data[5:0];
         3'd3: m_hi   = data[5:0];
         3'd4: m_gpio = data[1:0];
         default: ;
      endcase
   endtask

   task automatic probe(string req, logic [15:0] a);
      logic [5:0] blk;
      logic       hit;
      logic [7:0] sum;
      logic [1:0] en;
      logic [1:0] xa;
      blk = a[15:10];
      hit = (m_mode != 2'd0) && (blk >= m_lo) && (blk <= m_hi);
      sum = m_ofs + {2'b00, blk};
      en  = {m_mode == 2'd3, m_mode >= 2'd2};
      for (int i = 0; i < 2; i++)
         xa[i] = en[i] ? (hit ? sum[6+i] : m_ofs[6+i]) : m_gpio[i];
      @(negedge clk);
      cpu_addr = a;
      #1;
      chk(req, "addr_out", 32'(addr_out), 32'({hit ? sum[5:0] : blk, a[9:0]}));
      chk(req, "xa_out", 32'(xa_out), 32'(xa));
      chk(req, "xa_addr_en", 32'(xa_addr_en), 32'(en));
      chk(req, "cs_prog_n", 32'(cs_prog_n), 32'(!hit));
   endtask

   task automatic t_reset;
      #1;
      // R9 reset state visible at the pins
      chk("R9", "xa_out", 32'(xa_out), 32'h3);
      chk("R9", "cs_prog_n", 32'(cs_prog_n), 32'h1);
      probe("R9", 16'h0000);
   endtask

   task automatic t_mode_none;
      wr(3'd1, 8'h15);
      wr(3'd2, 8'd0);
      wr(3'd3, 8'd63);
      // R1 R4 mode 0 translates nothing even with a full window
      probe("R4", 16'h1234);
      probe("R2", 16'hFFFF);
      probe("R6", 16'h8001);
   endtask

   task automatic t_mode64;
      wr(3'd0, 8'd1);
      wr(3'd2, 8'd8);
      wr(3'd3, 8'd15);
      // R3 in-window sum
      probe("R3", 16'h2C55);
      // R4 outside window
      probe("R4", 16'h4C55);
      // R6 extended lines stay fallback
      probe("R6", 16'h3FFF);
   endtask

   task automatic t_mode128;
      wr(3'd0, 8'd2);
      wr(3'd1, 8'h7C);
      wr(3'd4, 8'd1);
      // R7 in window: sum 0x7C + 0x0A = 0x86 -> xa0 = 0, upper = 6
      probe("R7", 16'h2BCD);
      // R7 outside: xa0 from offset bit 6 = 1
      probe("R7", 16'h0123);
   endtask

   task automatic t_mode256;
      wr(3'd0, 8'd3);
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'd60);
      wr(3'd3, 8'd63);
      // R8 block 63 + 0xFF = 0x13E, carry dropped -> 0x3E
      probe("R8", 16'hFC00);
      chk("R8", "xa_out carry dropped", 32'(xa_out), 32'h0);
      probe("R8", 16'hF3FF);
      wr(3'd1, 8'h80);
      probe("R8", 16'h0000);
   endtask

   task automatic t_bounds;
      wr(3'd2, 8'd20);
      wr(3'd3, 8'd30);
      // R5 inclusive edges
      probe("R5", {6'd20, 10'h000});
      chk("R5", "lo edge in", 32'(cs_prog_n), 32'h0);
      probe("R5", {6'd30, 10'h3FF});
      chk("R5", "hi edge in", 32'(cs_prog_n), 32'h0);
      probe("R5", {6'd19, 10'h3FF});
      probe("R5", {6'd31, 10'h000});
      // R5 empty window
      wr(3'd2, 8'd40);
      wr(3'd3, 8'd39);
      probe("R5", {6'd40, 10'h000});
      probe("R5", {6'd39, 10'h000});
   endtask

   task automatic t_writes;
      wr(3'd0, 8'd0);
      wr(3'd4, 8'd2);
      // R10 fallback data write reaches the pins
      probe("R10", 16'h0000);
      chk("R10", "gpio write", 32'(xa_out), 32'h2);
      // R10 unused selectors change nothing
      wr(3'd5, 8'h00);
      wr(3'd6, 8'h00);
      wr(3'd7, 8'h00);
      probe("R10", 16'h0000);
      wr(3'd0, 8'd3);
      wr(3'd2, 8'd0);
      wr(3'd3, 8'd63);
      wr(3'd7, 8'h00);
      probe("R10", 16'h5555);
      // R1 mode code 1 written after 3
      wr(3'd0, 8'd1);
      probe("R1", 16'h5555);
   endtask

   initial begin
      #200_000ns;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_mode_none();
      t_mode64();
      t_mode128();
      t_mode256();
      t_bounds();
      t_writes();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule